// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block sits on the host side of a serial 8-bit converter that has a chip-select input, a host-driven I/O clock and a single serial data output. It drives chip select and the I/O clock, shifts in the eight result bits and enforces the converter's timing rules. All timing comes from the fast system clock through counters whose lengths are parameters. These are the settling delay after chip select falls, the high and low phase widths of the I/O clock, and the dead time needed for the conversion that each frame's eighth falling edge starts.

User logic asks for a frame with `startReq`. While the frame and the conversion wait that follows it run, the block holds `busy` high. It delivers each word with a one-cycle `resultValid` pulse. The converter shifts out the result of the conversion started by the previous frame, so each word belongs to the sample taken one request earlier. After reset the converter's register holds no real sample. The `DROP_FIRST` parameter therefore chooses whether the first frame after reset gives a word at all. If `startReq` is held high, frames run back to back. Chip select stays high for the whole conversion wait, so a conversion is never aborted.

Top module: `adc_host_reader`

## Requirements
- R1: `serClk` is low whenever `selN` is high. Each frame has exactly 8 `serClk` pulses, and every high phase and every low phase between pulses lasts exactly `HALF_CYC` system cycles.
- R2: After `selN` falls, it stays low with `serClk` low for exactly `SETUP_CYC` cycles before the first `serClk` rise.
- R3: `serData` is sampled in the last system cycle of each `serClk` high phase. The first sample is bit 7 of `resultData` and the eighth is bit 0.
- R4: After the eighth falling edge, `serClk` stays low for `HALF_CYC` cycles and then `selN` rises. `selN` then stays high for at least `CONV_CYC + 1` cycles before the next frame.
- R5: `resultValid` is a one-cycle pulse in the first cycle in which `selN` is high again after a frame. `resultData` changes only in a cycle in which `resultValid` is high.
- R6: A `startReq` sampled high while idle makes `busy` high and `selN` low from the next cycle on. `busy` stays high until the conversion wait ends. A `startReq` seen while `busy` is high starts no frame.
- R7: With `DROP_FIRST` = 1, the first frame after reset gives no `resultValid` pulse. Every later frame gives exactly one pulse, carrying the word sampled by the frame before it.
- R8: During and after reset, before any request: `selN` = 1, `serClk` = 0, `busy` = 0, `resultValid` = 0, `resultData` = 0.
- R9: With `startReq` held high, the next frame's `selN` falls exactly `CONV_CYC + 1` cycles after the previous frame's `selN` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one read-and-convert frame |
| serData | input | 1 | Serial result bit from the converter |
| selN | output | 1 | Active-low chip select to the converter |
| serClk | output | 1 | Generated I/O clock to the converter |
| busy | output | 1 | Frame or conversion wait in progress |
| resultValid | output | 1 | One-cycle strobe for a new word |
| resultData | output | 8 | Last delivered word, previous conversion's result |

## Verification
The bench builds the block with `SETUP_CYC` = 3, `HALF_CYC` = 2, `CONV_CYC` = 10 and `DROP_FIRST` = 1. These short values let a single run cover many frames. The run includes back-to-back chains, requests raised during the conversion wait, and all-ones and all-zeros words, and the bench still measures every phase length cycle by cycle. Because discarding is enabled, the suppressed first word and the one-frame lag between sample and delivery can both be observed at the ports.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int WORD_W = 8;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_CONV  = 3'd4
  } rd_state_t;

  typedef struct packed {
    logic capture;    // sample serData now (last cycle of a high phase)
    logic frameDone;  // last cycle of the final low phase
  } rd_strobe_t;

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int SETUP_CYC = 175,
  parameter int HALF_CYC  = 57,
  parameter int CONV_CYC  = 2125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output logic       selN,
  output logic       serClk,
  output logic       busy,
  output rd_strobe_t strobe
);

  localparam int MAX_SH = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int MAX_C  = (MAX_SH > CONV_CYC) ? MAX_SH : CONV_CYC;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] SETUP_LOAD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HALF_LOAD  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] CONV_LOAD  = CW'(CONV_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  rd_state_t        state;
  logic [CW-1:0]    cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state <= ST_SETUP;
            cnt   <= SETUP_LOAD;
          end
        end
        ST_SETUP: begin
          if (cntZero) begin
            state  <= ST_HIGH;
            cnt    <= HALF_LOAD;
            bitIdx <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (cntZero) begin
            state <= ST_LOW;
            cnt   <= HALF_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LOW: begin
          if (cntZero) begin
            if (bitIdx == LAST_IDX) begin
              state <= ST_CONV;
              cnt   <= CONV_LOAD;
            end else begin
              state  <= ST_HIGH;
              cnt    <= HALF_LOAD;
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (cntZero) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign selN   = (state == ST_IDLE) || (state == ST_CONV);
  assign serClk = (state == ST_HIGH);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    strobe.capture   = (state == ST_HIGH) && cntZero;
    strobe.frameDone = (state == ST_LOW) && cntZero && (bitIdx == LAST_IDX);
  end

  // ---- checks ----
  logic [CW-1:0] hiLen;
  always_ff @(posedge clk) begin
    if (!rstN)       hiLen <= '0;
    else if (serClk) hiLen <= hiLen + 1'b1;
    else             hiLen <= '0;
  end

  a_r1_clk_gated_by_sel: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> !selN);

  a_r1_high_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serClk) |-> (hiLen == CW'(HALF_CYC)));

  a_r2_no_clk_at_select: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selN) |-> !serClk);

  a_r6_frame_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selN) |-> $past(!busy));

endmodule

// File: rtl/adc_rd_dpath.sv
module adc_rd_dpath
  import adc_rd_pkg::*;
#(
  parameter bit DROP_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serData,
  input  rd_strobe_t        strobe,
  output logic              resultValid,
  output logic [WORD_W-1:0] resultData
);

  logic [WORD_W-1:0] shiftReg;
  logic              firstPending;
  logic              keepWord;

  generate
    if (DROP_FIRST) begin : g_drop
      assign keepWord = !firstPending;
    end else begin : g_keep
      assign keepWord = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg     <= '0;
      resultData   <= '0;
      resultValid  <= 1'b0;
      firstPending <= 1'b1;
    end else begin
      resultValid <= 1'b0;
      if (strobe.capture) begin
        shiftReg <= {shiftReg[WORD_W-2:0], serData};
      end
      if (strobe.frameDone) begin
        firstPending <= 1'b0;
        if (keepWord) begin
          resultData  <= shiftReg;
          resultValid <= 1'b1;
        end
      end
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(resultData));

endmodule

// File: rtl/adc_host_reader.sv
module adc_host_reader
  import adc_rd_pkg::*;
#(
  parameter int SETUP_CYC  = 175,
  parameter int HALF_CYC   = 57,
  parameter int CONV_CYC   = 2125,
  parameter bit DROP_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       serData,
  output logic       selN,
  output logic       serClk,
  output logic       busy,
  output logic       resultValid,
  output logic [7:0] resultData
);

  rd_strobe_t strobe;

  adc_rd_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .HALF_CYC (HALF_CYC),
    .CONV_CYC (CONV_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .selN    (selN),
    .serClk  (serClk),
    .busy    (busy),
    .strobe  (strobe)
  );

  adc_rd_dpath #(
    .DROP_FIRST(DROP_FIRST)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .serData    (serData),
    .strobe     (strobe),
    .resultValid(resultValid),
    .resultData (resultData)
  );

  a_r4_valid_after_select: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (selN && busy && $past(!selN)));

endmodule

// File: tb/sim_adc_host_reader.sv
`timescale 1ns/1ps
module sim_adc_host_reader;

  localparam int SETUP = 3;
  localparam int HALF  = 2;
  localparam int CONV  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic serData;
  logic selN, serClk, busy, resultValid;
  logic [7:0] resultData;

  always #4 clk = ~clk;

  adc_host_reader #(
    .SETUP_CYC(SETUP), .HALF_CYC(HALF), .CONV_CYC(CONV), .DROP_FIRST(1'b1)
  ) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .serData(serData),
    .selN(selN), .serClk(serClk), .busy(busy),
    .resultValid(resultValid), .resultData(resultData)
  );

  // converter model: word from previous frame, MSB first, shift on falling clock
  logic [7:0] adcWord = 8'hA5;
  logic [7:0] shiftOut = 8'h00;
  logic [7:0] nextAnalog = 8'h00;
  int fallCnt = 0;
  assign serData = shiftOut[7];

  always @(negedge selN) begin
    shiftOut <= adcWord;
    fallCnt  <= 0;
  end
  always @(negedge serClk) begin
    if (fallCnt == 7) adcWord <= nextAnalog;
    shiftOut <= {shiftOut[6:0], 1'b0};
    fallCnt  <= fallCnt + 1;
  end

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard
  logic [7:0] expQ[$];
  logic [7:0] lastSample = 8'h00;
  int validCnt = 0;
  int frames = 0;
  bit b2bMode = 1'b0;
  bit monOn = 1'b0;

  bit pSel = 1'b1, pClk = 1'b0, pValid = 1'b0, firstFall = 1'b1;
  int setupCnt = 0, hiCnt = 0, loCnt = 0, selHiCnt = 0, pulses = 0;
  logic [7:0] lastData = 8'h00;

  always @(negedge clk) begin
    if (monOn) begin
      if (pSel && !selN) begin
        if (!firstFall) begin
          chk(selHiCnt >= CONV + 1, "R4 select high wait", selHiCnt, CONV + 1);
          if (b2bMode) chk(selHiCnt == CONV + 1, "R9 back-to-back gap", selHiCnt, CONV + 1);
        end
        firstFall = 1'b0;
        frames++;
        setupCnt = 0; pulses = 0; selHiCnt = 0;
      end
      if (selN) selHiCnt++;
      if (!selN && !serClk && pulses == 0) setupCnt++;
      if (!pClk && serClk) begin
        if (pulses == 0) chk(setupCnt == SETUP, "R2 setup length", setupCnt, SETUP);
        else chk(loCnt == HALF, "R1 low phase", loCnt, HALF);
        hiCnt = 0;
      end
      if (serClk) hiCnt++;
      if (pClk && !serClk) begin
        chk(hiCnt == HALF, "R1 high phase", hiCnt, HALF);
        pulses++;
        loCnt = 0;
      end
      if (!serClk && !selN && pulses > 0) loCnt++;
      if (!pSel && selN && !firstFall) begin
        chk(pulses == 8, "R1 pulse count", pulses, 8);
        chk(loCnt == HALF, "R4 tail low phase", loCnt, HALF);
      end
      if (selN && serClk) chk(1'b0, "R1 clock while deselected", 1, 0);

      if (resultValid) begin
        chk(!pValid, "R5 valid pulse width", 2, 1);
        chk(!pSel && selN, "R5 valid timing", int'(pSel), 0);
        chk(busy, "R6 busy during wait", int'(busy), 1);
        if (expQ.size() == 0) begin
          chk(1'b0, "R7 unexpected word", int'(resultData), -1);
        end else begin
          automatic logic [7:0] e = expQ.pop_front();
          chk(resultData == e, "R3 word value", int'(resultData), int'(e));
        end
        validCnt++;
        lastData = resultData;
      end else if (resultData != lastData) begin
        chk(1'b0, "R5 data changed without valid", int'(resultData), int'(lastData));
      end
      pSel = selN; pClk = serClk; pValid = resultValid;
    end
  end

  task automatic pulseStart();
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy && !selN, "R6 start accepted", int'(busy), 1);
  endtask

  task automatic doFrame(input logic [7:0] sample, input bit expectValid);
    int vc;
    nextAnalog = sample;
    if (expectValid) expQ.push_back(lastSample);
    vc = validCnt;
    pulseStart();
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(validCnt == vc + (expectValid ? 1 : 0), "R7 words per frame",
        validCnt - vc, expectValid ? 1 : 0);
    lastSample = sample;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(selN == 1'b1 && serClk == 1'b0, "R8 pins in reset", int'(selN), 1);
    chk(busy == 1'b0 && resultValid == 1'b0 && resultData == 8'h00, "R8 status in reset",
        int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    repeat (3) @(negedge clk);
    chk(selN == 1'b1 && serClk == 1'b0 && busy == 1'b0 && resultValid == 1'b0,
        "R8 idle after reset", int'(busy), 0);

    // R7: first word after reset dropped
    doFrame(8'h3C, 1'b0);
    // main pattern incl. all-ones and all-zeros
    doFrame(8'h81, 1'b1);
    doFrame(8'hFF, 1'b1);
    doFrame(8'h00, 1'b1);
    doFrame(8'h5A, 1'b1);
    doFrame(8'h01, 1'b1);

    // R6: request during conversion wait is ignored
    begin
      int fc;
      nextAnalog = 8'hC3;
      expQ.push_back(lastSample);
      pulseStart();
      while (!selN) @(negedge clk);
      startReq = 1'b1;
      repeat (3) @(negedge clk);
      startReq = 1'b0;
      fc = frames;
      while (busy) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(selN == 1'b1 && frames == fc, "R6 request while busy ignored", frames, fc);
      lastSample = 8'hC3;
    end

    // R9: back-to-back with request held
    begin
      int fc;
      logic [7:0] s [3];
      s[0] = 8'h12; s[1] = 8'hED; s[2] = 8'h77;
      fc = frames;
      nextAnalog = s[0];
      expQ.push_back(lastSample);
      @(negedge clk);
      startReq = 1'b1;
      while (frames != fc + 1) @(posedge clk);
      lastSample = s[0];
      b2bMode = 1'b1;
      for (int i = 1; i < 3; i++) begin
        while (frames != fc + 1 + i) @(posedge clk);
        nextAnalog = s[i];
        expQ.push_back(lastSample);
        lastSample = s[i];
      end
      @(negedge clk);
      startReq = 1'b0;
      while (busy) @(negedge clk);
      b2bMode = 1'b0;
      chk(frames == fc + 3, "R9 frame count", frames - fc, 3);
    end

    doFrame(8'h99, 1'b1);
    chk(expQ.size() == 0, "R7 all words delivered", expQ.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule